// File: doc/BRIEF.md
# NAND Flash Strobe Timing Generator

This block drives the write-enable, read-enable and chip-enable strobes of an asynchronous 8-bit NAND flash bus. A requester asks for one write cycle or one read cycle. The block runs the cycle with phase lengths taken from a packed 32-bit timing register. Low and high phases are set by edge positions inside the cycle, not by separate durations. A read captures the bus data when its low phase ends and then keeps the bus idle for a turnaround time. A request may also ask the block to wait for the device: the block counts a fixed busy delay and then waits until a synchronised ready/busy pin reads ready. A one-cycle done pulse closes every cycle.

The timing register is protected. A write to it takes effect only when the register write just before it put the unlock key into the lock register. A status output gives the controller-ready bit and the synchronised device-ready bit.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, all three strobes are high and the data bus is not driven. ready_o is 1, done_o is 0, rdata_o is 0 and the timing register holds its reset value (all fields zero). The unlock state is cleared.
- R2: The timing register fields are: bits 3:0 write-low edge, bits 7:4 write-high edge, bits 11:8 read-low edge, bits 15:12 read-high edge, bits 18:16 turnaround, bits 23:19 busy delay, bits 25:24 chip-enable lead. Bits 31:26 are ignored.
- R3: A write cycle holds nand_we_no low for (write-low + 1) cycles and then high for (write-high − write-low) cycles. nand_ce_no is low and nand_io_o carries the request data with nand_io_oe_o high through both phases.
- R4: A read cycle first holds nand_ce_no low with nand_re_no high for chip-enable-lead cycles. It then holds nand_re_no low for (read-low + 1) cycles and high for (read-high − read-low) cycles. rdata_o takes nand_io_i as sampled in the last low cycle and changes at no other time.
- R5: When a high edge is not greater than its low edge, that high phase lasts exactly one cycle.
- R6: After the read-high phase, all strobes stay high and ready_o stays 0 for turnaround cycles.
- R7: When req_busy_i was 1 at acceptance, the strobe and turnaround phases are followed by busy-delay cycles. The block then waits until the ready/busy pin, passed through a two-flop synchroniser, reads 1.
- R8: A timing register write (cfg_sel_i = 1) is applied only if the register write just before it was a lock write (cfg_sel_i = 0) with cfg_wdata_i[15:0] = 0xA25E.
- R9: The unlock covers one register write only. Any register write clears it, except a lock write of the key, which sets it again.
- R10: A request (req_i = 1) is accepted only while ready_o = 1, which is only when the block is idle. A request raised at any other time has no effect.
- R11: done_o is high for exactly one cycle after the last phase of each cycle. ready_o is 1 in the next cycle.
- R12: status_o[1] equals ready_o. status_o[0] is nand_rb_i delayed through two flops.
- R13: nand_we_no and nand_re_no are never low together. nand_ce_no is low whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 selects the lock register, 1 selects the timing register |
| cfg_wdata_i | input | 32 | Register write data |
| req_i | input | 1 | Cycle request |
| req_rd_i | input | 1 | 1 requests a read cycle, 0 a write cycle |
| req_busy_i | input | 1 | Wait for the device after the cycle |
| req_wdata_i | input | 8 | Data for a write cycle |
| ready_o | output | 1 | Block idle and able to accept a request |
| done_o | output | 1 | One-cycle end-of-cycle pulse |
| rdata_o | output | 8 | Captured read data |
| nand_we_no | output | 1 | Write enable, active low |
| nand_re_no | output | 1 | Read enable, active low |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_io_o | output | 8 | Bus data out |
| nand_io_oe_o | output | 1 | Bus output enable |
| nand_io_i | input | 8 | Bus data in |
| nand_rb_i | input | 1 | Device ready/busy, 1 = ready |
| status_o | output | 2 | {controller ready, synchronised device ready} |

## Verification
The bench targets edge positions where the high edge equals the low edge or lies below it. A design without the clamp would wrap its counter and stretch the high phase to about fifteen cycles. It also checks timing writes with no unlock, with a wrong key in between, and twice after one unlock. A sticky unlock or a missing one would show up as the wrong phase lengths in the cycle that follows. The busy test keeps ready/busy low past the busy delay while req_i stays high. This catches a block that samples the pin too early, one that skips the synchroniser, and one that takes a second request before its done pulse.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  localparam int TIMING_W = 32;
  localparam int CNT_W    = 5;

  // field order sets the register bit positions
  typedef struct packed {
    logic [5:0] rsvd;
    logic [1:0] ce_lead;
    logic [4:0] busy_dly;
    logic [2:0] turn;
    logic [3:0] rd_hi;
    logic [3:0] rd_lo;
    logic [3:0] wr_hi;
    logic [3:0] wr_lo;
  } timing_t;

  typedef enum logic [3:0] {
    S_IDLE, S_LEAD, S_WLOW, S_WHIGH, S_RLOW, S_RHIGH, S_TURN, S_BUSY, S_DONE
  } phase_e;

  function automatic logic [3:0] high_len(input logic [3:0] hi, input logic [3:0] lo);
    return (hi > lo) ? (hi - lo) : 4'd1;
  endfunction
endpackage

// File: rtl/nsg_key_reg.sv
module nsg_key_reg
  import nsg_pkg::*;
#(
  parameter logic [15:0]         LOCK_KEY = 16'hA25E,
  parameter logic [TIMING_W-1:0] RST_VAL  = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                sel_i,
  input  logic [TIMING_W-1:0] wdata_i,
  output timing_t             timing_o
);
  logic                unlocked_q;
  logic [TIMING_W-1:0] timing_q;
  logic                key_hit;

  assign key_hit = !sel_i && (wdata_i[15:0] == LOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      timing_q   <= RST_VAL;
    end else if (wr_i) begin
      unlocked_q <= key_hit;
      if (sel_i && unlocked_q) timing_q <= wdata_i;
    end
  end

  assign timing_o = timing_t'(timing_q);

  p_unlock_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !key_hit) |=> !unlocked_q);
  p_locked_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && !unlocked_q) |=> $stable(timing_q));
endmodule

// File: rtl/nsg_sync.sv
module nsg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/nsg_seq.sv
module nsg_seq
  import nsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  timing_t           timing_i,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] io_i,
  input  logic              rb_sync_i,
  output logic              we_no,
  output logic              re_no,
  output logic              ce_no,
  output logic [DATA_W-1:0] io_o,
  output logic              io_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              done_o
);
  phase_e             state_q, state_d, tail_state;
  logic [CNT_W-1:0]   cnt_q, cnt_d, tail_cnt, cnt_dec;
  logic               is_rd_q, busy_q, last, accept;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic [5:0]         unused_rsvd;

  assign unused_rsvd = timing_i.rsvd;
  assign last    = (cnt_q == '0);
  assign cnt_dec = cnt_q - 1'b1;
  assign accept  = (state_q == S_IDLE) && req_i;

  // after strobes (and turnaround): optional device wait, then done
  always_comb begin
    if (busy_q) begin
      tail_state = S_BUSY;
      tail_cnt   = CNT_W'(timing_i.busy_dly);
    end else begin
      tail_state = S_DONE;
      tail_cnt   = '0;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      S_IDLE: if (req_i) begin
        if (!rd_i) begin
          state_d = S_WLOW;
          cnt_d   = CNT_W'(timing_i.wr_lo);
        end else if (timing_i.ce_lead != '0) begin
          state_d = S_LEAD;
          cnt_d   = CNT_W'(timing_i.ce_lead - 2'd1);
        end else begin
          state_d = S_RLOW;
          cnt_d   = CNT_W'(timing_i.rd_lo);
        end
      end
      S_LEAD: if (last) begin
        state_d = S_RLOW;
        cnt_d   = CNT_W'(timing_i.rd_lo);
      end else cnt_d = cnt_dec;
      S_WLOW: if (last) begin
        state_d = S_WHIGH;
        cnt_d   = CNT_W'(high_len(timing_i.wr_hi, timing_i.wr_lo) - 4'd1);
      end else cnt_d = cnt_dec;
      S_WHIGH: if (last) begin
        state_d = tail_state;
        cnt_d   = tail_cnt;
      end else cnt_d = cnt_dec;
      S_RLOW: if (last) begin
        state_d = S_RHIGH;
        cnt_d   = CNT_W'(high_len(timing_i.rd_hi, timing_i.rd_lo) - 4'd1);
      end else cnt_d = cnt_dec;
      S_RHIGH: if (last) begin
        if (timing_i.turn != '0) begin
          state_d = S_TURN;
          cnt_d   = CNT_W'(timing_i.turn - 3'd1);
        end else begin
          state_d = tail_state;
          cnt_d   = tail_cnt;
        end
      end else cnt_d = cnt_dec;
      S_TURN: if (last) begin
        state_d = tail_state;
        cnt_d   = tail_cnt;
      end else cnt_d = cnt_dec;
      S_BUSY: if (!last) cnt_d = cnt_dec;
              else if (rb_sync_i) state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
      busy_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        is_rd_q <= rd_i;
        busy_q  <= busy_i;
        wdata_q <= wdata_i;
      end
      if (state_q == S_RLOW && last) rdata_q <= io_i;
    end
  end

  assign we_no   = (state_q != S_WLOW);
  assign re_no   = (state_q != S_RLOW);
  assign ce_no   = !(state_q inside {S_LEAD, S_WLOW, S_WHIGH, S_RLOW, S_RHIGH});
  assign io_oe_o = (state_q inside {S_WLOW, S_WHIGH});
  assign io_o    = wdata_q;
  assign rdata_o = rdata_q;
  assign ready_o = (state_q == S_IDLE);
  assign done_o  = (state_q == S_DONE);

  p_strobe_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> re_no);
  p_ce_cover_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> !ce_no);
  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));
  p_idle_stay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !req_i) |=> ready_o);
  p_rdata_when_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> ($past(!re_no) && re_no && is_rd_q));
  p_turn_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TURN) |-> (ce_no && !ready_o && !io_oe_o));
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] LOCK_KEY    = 16'hA25E,
  parameter logic [31:0] RST_TIMING  = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic              cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              req_i,
  input  logic              req_rd_i,
  input  logic              req_busy_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic              nand_ce_no,
  output logic [DATA_W-1:0] nand_io_o,
  output logic              nand_io_oe_o,
  input  logic [DATA_W-1:0] nand_io_i,
  input  logic              nand_rb_i,
  output logic [1:0]        status_o
);
  timing_t timing;
  logic    rb_sync;

  nsg_key_reg #(.LOCK_KEY(LOCK_KEY), .RST_VAL(RST_TIMING)) u_key_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cfg_wr_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .timing_o(timing)
  );

  nsg_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(nand_rb_i), .q_o(rb_sync)
  );

  nsg_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .timing_i(timing),
    .req_i(req_i), .rd_i(req_rd_i), .busy_i(req_busy_i), .wdata_i(req_wdata_i),
    .io_i(nand_io_i), .rb_sync_i(rb_sync),
    .we_no(nand_we_no), .re_no(nand_re_no), .ce_no(nand_ce_no),
    .io_o(nand_io_o), .io_oe_o(nand_io_oe_o), .rdata_o(rdata_o),
    .ready_o(ready_o), .done_o(done_o)
  );

  assign status_o = {ready_o, rb_sync};

  p_status_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] == ready_o) && (status_o[0] == $past(nand_rb_i, 2) || $past(!rst_ni, 2)));
endmodule

// File: tb/sim_nand_strobe_gen.sv
module sim_nand_strobe_gen;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_wr = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0;
  logic        req = 0, req_rd = 0, req_busy = 0;
  logic [7:0]  req_wdata = '0, io_in = '0;
  logic        rb = 1'b1;
  logic        ready, done, we_n, re_n, ce_n, io_oe;
  logic [7:0]  rdata, io_out;
  logic [1:0]  status;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  // model state: entry {wait, oe, done, ce, re, we}
  logic [5:0]  q[$];
  logic [31:0] m_tim = '0;
  bit          m_unl = 0, s1 = 0, s2 = 0;

  always #2 clk = ~clk;

  nand_strobe_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .req_i(req), .req_rd_i(req_rd), .req_busy_i(req_busy),
    .req_wdata_i(req_wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_ce_no(ce_n), .nand_io_o(io_out),
    .nand_io_oe_o(io_oe), .nand_io_i(io_in), .nand_rb_i(rb), .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int wl, int wh, int rl, int rh, int ta, int bd, int cl);
    return 32'(wl) | (32'(wh) << 4) | (32'(rl) << 8) | (32'(rh) << 12) |
           (32'(ta) << 16) | (32'(bd) << 19) | (32'(cl) << 24);
  endfunction

  function automatic void push_n(logic [5:0] e, int n);
    for (int i = 0; i < n; i++) q.push_back(e);
  endfunction

  function automatic int hlen(int h, int l);
    return (h > l) ? h - l : 1;
  endfunction

  // R2 field positions used here
  function automatic void build(bit rd, bit bz);
    int wl = int'(m_tim[3:0]),   wh = int'(m_tim[7:4]);
    int rl = int'(m_tim[11:8]),  rh = int'(m_tim[15:12]);
    int ta = int'(m_tim[18:16]), bd = int'(m_tim[23:19]), cl = int'(m_tim[25:24]);
    if (rd) begin
      push_n(6'b000_011, cl);
      push_n(6'b000_001, rl + 1);
      push_n(6'b000_011, hlen(rh, rl));
      push_n(6'b000_111, ta);
    end else begin
      push_n(6'b010_010, wl + 1);
      push_n(6'b010_011, hlen(wh, wl));
    end
    if (bz) begin
      push_n(6'b000_111, bd);
      q.push_back(6'b100_111);
    end
    q.push_back(6'b001_111);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      q.delete(); m_tim = '0; m_unl = 0; s1 = 0; s2 = 0;
    end else begin
      if (cfg_wr) begin
        if (!cfg_sel) m_unl = (cfg_wdata[15:0] == 16'hA25E);
        else begin
          if (m_unl) m_tim = cfg_wdata;
          m_unl = 0;
        end
      end
      if (q.size() == 0) begin
        if (req) build(req_rd, req_busy);
      end else if (q[0][5]) begin
        if (s2) void'(q.pop_front());
      end else void'(q.pop_front());
      s2 = s1; s1 = rb;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      logic [5:0] e;
      bit idle;
      idle = (q.size() == 0);
      e = idle ? 6'b000_111 : q[0];
      chk({ce_n, re_n, we_n} == e[2:0], cur_req, {ce_n, re_n, we_n}, e[2:0]);
      chk(done == e[3], "R11", done, e[3]);
      chk(ready == idle, "R10", ready, idle);
      chk(io_oe == e[4], "R3", io_oe, e[4]);
      if (e[4]) chk(io_out == req_wdata, "R3", io_out, req_wdata);
      chk(status == {idle, s2}, "R12", status, {idle, s2});
      chk(we_n || re_n, "R13", {we_n, re_n}, 2'b11);
    end
  end

  always @(posedge clk) if (cyc > 100000) begin
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic cfg_write(input bit sel, input logic [31:0] v);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic unlock();
    cfg_write(0, 32'h0000_A25E);
  endtask

  task automatic run(input bit rd, input bit bz, input logic [7:0] d);
    @(negedge clk); req = 1; req_rd = rd; req_busy = bz; req_wdata = d;
    @(negedge clk); req = 0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(ready && we_n && re_n && ce_n && !done && !io_oe, "R1", {ready, we_n, re_n, ce_n}, 4'hF);
    chk(rdata == 8'h00, "R1", rdata, 0);
    repeat (3) @(negedge clk);

    // reset timing, all zero: one-cycle phases
    cur_req = "R3"; run(0, 0, 8'h5A);
    cur_req = "R4"; io_in = 8'hC3; run(1, 0, 8'h00);
    chk(rdata == 8'hC3, "R4", rdata, 8'hC3);

    // timing write with no unlock is dropped
    cfg_write(1, mk(2, 5, 3, 6, 4, 3, 2));
    cur_req = "R8"; run(0, 0, 8'hA1);

    // R2 layout, R3 write, R4 read with lead, R6 turnaround
    unlock(); cfg_write(1, mk(2, 5, 3, 6, 4, 3, 2) | 32'hFC00_0000);
    cur_req = "R3"; run(0, 0, 8'h3C);
    cur_req = "R6"; io_in = 8'h96; run(1, 0, 8'h00);
    chk(rdata == 8'h96, "R4", rdata, 8'h96);
    io_in = 8'h11;
    repeat (4) @(negedge clk);
    chk(rdata == 8'h96, "R4", rdata, 8'h96);

    // R9: a wrong-key lock write consumes the unlock
    unlock(); cfg_write(0, 32'h0000_1234); cfg_write(1, mk(4, 4, 5, 2, 0, 0, 0));
    cur_req = "R9"; run(0, 0, 8'h77);

    // R5 clamp; then a second timing write after one unlock is dropped (R9)
    unlock(); cfg_write(1, mk(4, 4, 5, 2, 0, 0, 0));
    cfg_write(1, mk(1, 9, 1, 9, 1, 1, 1));
    cur_req = "R5"; run(0, 0, 8'hE7);
    io_in = 8'h42; run(1, 0, 8'h00);
    chk(rdata == 8'h42, "R5", rdata, 8'h42);

    // R7 busy wait with pin low past the delay; R10 request held high throughout
    unlock(); cfg_write(1, mk(1, 3, 1, 3, 2, 4, 1));
    cur_req = "R7";
    @(negedge clk); rb = 0; req = 1; req_rd = 0; req_busy = 1; req_wdata = 8'hB4;
    repeat (18) @(negedge clk);
    rb = 1;
    repeat (12) @(negedge clk);
    req = 0;
    while (q.size() != 0) @(negedge clk);
    cur_req = "R7"; run(1, 1, 8'h00);
    repeat (4) @(negedge clk);
    chk(status == 2'b11, "R12", status, 2'b11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule